// File: doc/BRIEF.md
# Keyed-Write Watchdog / Interval Timer

This peripheral counts prescaled clock ticks in an 8-bit up-counter. An 8-bit control/status register sets the enable, the overflow mode, the reset kind and the prescale ratio. Both registers sit behind a 16-bit write bus. A write takes effect only when its upper byte carries the key for the addressed register, so a stray store into the block does nothing.

When the counter wraps from 0xFF to 0x00, the block acts in one of two modes. In watchdog mode it sets a watchdog flag and sends a one-cycle reset request to an external reset generator. In interval mode it sets an interval flag and raises a level interrupt, which stays high until software clears that flag. Software keeps the watchdog from firing by reloading the counter before it wraps. Each reload also clears the prescaler, so the next tick is always a full prescale period away.

Top module: `keyed_wdt`

## Requirements
- R1: A write with wr_addr=0 and upper byte 0x5A loads wr_data[7:0] into the counter and clears the prescaler, so the first tick after the write takes a full prescale period.
- R2: A write with wr_addr=1 and upper byte 0xA5 loads the control/status byte: bit7 enable, bit6 mode (1 watchdog, 0 interval), bit5 reset kind, bit4 watchdog flag, bit3 interval flag, bits2:0 clock select.
- R3: A write whose upper byte is not the key of the addressed register changes no state. This includes a write that carries the other register's key.
- R4: Clock select code c gives one counter increment every 2^(BASE_SHIFT+c) clocks. The default BASE_SHIFT is 5, which gives ratios from 1/32 to 1/4096.
- R5: While bit7 is 0 the counter holds its value. Setting bit7 resumes counting from the held value.
- R6: In watchdog mode, a wrap from 0xFF to 0x00 sets bit4 and drives rst_req high for exactly one cycle. rst_kind always shows bit5.
- R7: In interval mode, a wrap sets bit3, and irq is high exactly while bit3 is set.
- R8: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged.
- R9: After reset the counter and the control/status byte are 0, and rst_req, rst_kind and irq are low.
- R10: rd_data shows the counter (rd_addr=0) or the control/status byte (rd_addr=1) one clock after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write target: 0 counter, 1 control/status |
| wr_data | input | 16 | Key in [15:8], value in [7:0] |
| rd_addr | input | 1 | Read target: 0 counter, 1 control/status |
| rd_data | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle reset request on a watchdog overflow |
| rst_kind | output | 1 | Reset kind selected by bit5 |
| irq | output | 1 | Interval interrupt, high while bit3 is set |

## Verification
A prescaler that is not cleared on a counter reload makes the overflow arrive early by up to one prescale period. This is visible as a short edge count between the reload and rst_req. A bad key decode shows on the next readback as a counter or control byte that changed when it should not have. A flag that misses its set or its clear is visible within one cycle, either on irq or as a second rst_req pulse, and is also visible on the control/status readback.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int          CNT_W   = 8;
  localparam int          SEL_W   = 3;
  localparam logic [7:0]  KEY_CNT = 8'h5A;
  localparam logic [7:0]  KEY_CSR = 8'hA5;

  // packed so that bit7 is run_en and bits2:0 are clk_sel
  typedef struct packed {
    logic             run_en;
    logic             wd_mode;
    logic             rst_type;
    logic             wd_flag;
    logic             iv_flag;
    logic [SEL_W-1:0] clk_sel;
  } ctl_t;
endpackage

// File: rtl/wdt_regbus.sv
module wdt_regbus
  import keyed_wdt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cnt_wr,
  output logic          ctl_wr,
  output logic [7:0]    wr_val
);
  localparam int KEY_LO = DW - 8;

  logic [7:0] key;

  always_comb begin
    key    = wr_data[DW-1:KEY_LO];
    wr_val = wr_data[7:0];
    cnt_wr = wr_en && !wr_addr && (key == KEY_CNT);
    ctl_wr = wr_en &&  wr_addr && (key == KEY_CSR);
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_SHIFT = 5,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int DIV_W = BASE_SHIFT + NSEL - 1;

  logic [DIV_W-1:0] div_q;
  logic [NSEL-1:0]  term;

  for (genvar c = 0; c < NSEL; c++) begin : g_tap
    assign term[c] = &div_q[BASE_SHIFT+c-1:0];
  end

  assign tick = run && term[sel];

  always_ff @(posedge clk) begin
    if (rst || clr)
      div_q <= '0;
    else if (run)
      div_q <= div_q + DIV_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  logic [CW-1:0] cnt_q;

  assign cnt = cnt_q;
  assign ovf = tick && !load && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (tick)
      cnt_q <= cnt_q + CW'(1);
  end

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == '0)); // R6
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_SHIFT = 5,
  parameter int BUS_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [7:0]       rd_data,
  output logic             rst_req,
  output logic             rst_kind,
  output logic             irq
);
  logic             cnt_wr, ctl_wr, tick, ovf;
  logic [7:0]       wr_val;
  logic [CNT_W-1:0] cnt_val;
  ctl_t             ctl_q, ctl_d, wv;

  wdt_regbus #(.DW(BUS_W)) u_bus (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_wr(cnt_wr), .ctl_wr(ctl_wr), .wr_val(wr_val)
  );

  wdt_prescaler #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_q.run_en), .clr(cnt_wr),
    .sel(ctl_q.clk_sel), .tick(tick)
  );

  wdt_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_wr), .load_val(wr_val[CNT_W-1:0]),
    .tick(tick), .cnt(cnt_val), .ovf(ovf)
  );

  assign wv = ctl_t'(wr_val);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d.run_en   = wv.run_en;
      ctl_d.wd_mode  = wv.wd_mode;
      ctl_d.rst_type = wv.rst_type;
      ctl_d.clk_sel  = wv.clk_sel;
      ctl_d.wd_flag  = ctl_q.wd_flag & wv.wd_flag;
      ctl_d.iv_flag  = ctl_q.iv_flag & wv.iv_flag;
    end
    if (ovf) begin
      if (ctl_q.wd_mode) ctl_d.wd_flag = 1'b1;
      else               ctl_d.iv_flag = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
      rd_data <= '0;
    end else begin
      ctl_q   <= ctl_d;
      irq     <= ctl_d.iv_flag;
      rst_req <= ovf && ctl_q.wd_mode;
      rd_data <= rd_addr ? 8'(ctl_q) : 8'(cnt_val);
    end
  end

  assign rst_kind = ctl_q.rst_type;

  AST_CTL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !ovf) |=> $stable(ctl_q)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.run_en && !cnt_wr) |=> $stable(cnt_val)); // R5
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R6
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ovf && !ctl_q.wd_mode)); // R7
  AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!ovf && !ctl_q.iv_flag && !ctl_q.wd_flag) |=> (!ctl_q.iv_flag && !ctl_q.wd_flag)); // R8
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  localparam int BS = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_data;
  logic        rst_req, rst_kind, irq;

  int checks = 0, fails = 0, cyc = 0;

  keyed_wdt #(.BASE_SHIFT(BS), .BUS_W(16)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req),
    .rst_kind(rst_kind), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic wait_out(input bit use_irq, output int n);
    n = 0;
    while (((use_irq ? irq : rst_req) == 1'b0) && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  function automatic int period(input int code, input int start);
    return (1 << (BS + code)) * (256 - start);
  endfunction

  function automatic logic [7:0] ctl_model(input logic [7:0] old, input logic [7:0] v);
    return {v[7:5], old[4] & v[4], old[3] & v[3], v[2:0]};
  endfunction

  initial begin
    logic [7:0] v, v1, v2, exp_cnt, exp_ctl, val, key;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 / R10 reset state
    rd(1'b0, v); chk("R9 cnt", v, 0);
    rd(1'b1, v); chk("R9 ctl", v, 0);
    chk("R9 rst_req", rst_req, 0); chk("R9 irq", irq, 0); chk("R9 rst_kind", rst_kind, 0);

    // R1 R2 R3 R10 random keyed writes, counter held disabled
    exp_cnt = 0; exp_ctl = 0;
    for (int i = 0; i < 40; i++) begin
      logic sel, good;
      sel  = 1'($urandom % 2);
      good = ($urandom % 3) != 0;
      val  = 8'($urandom);
      if (sel) val[7] = 1'b0;
      if (good) key = sel ? 8'hA5 : 8'h5A;
      else begin
        key = 8'($urandom);
        if (key == (sel ? 8'hA5 : 8'h5A)) key = key ^ 8'h01;
      end
      wr(sel, {key, val});
      if (good) begin
        if (sel) exp_ctl = ctl_model(exp_ctl, val);
        else     exp_cnt = val;
      end
      rd(1'b0, v); chk(good ? "R1 cnt" : "R3 cnt", v, exp_cnt);
      rd(1'b1, v); chk(good ? "R2 ctl" : "R3 ctl", v, exp_ctl);
    end
    wr(1'b1, 16'hA500);

    // R4 R6 watchdog overflow, code 0
    wr(1'b0, 16'h5AFE);
    wr(1'b1, 16'hA5C0);
    wait_out(1'b0, n); chk("R4 period code0", n, period(0, 8'hFE));
    @(negedge clk); chk("R6 pulse one cycle", rst_req, 0);
    chk("R6 rst_kind low", rst_kind, 0);
    wr(1'b1, 16'hA550);
    rd(1'b1, v); chk("R8 write1 keeps wd flag", v, 8'h50);
    wr(1'b1, 16'hA540);
    rd(1'b1, v); chk("R8 write0 clears wd flag", v, 8'h40);

    // R4 R6 code 2 with reset kind set
    wr(1'b0, 16'h5AF0);
    wr(1'b1, 16'hA5E2);
    wait_out(1'b0, n); chk("R4 period code2", n, period(2, 8'hF0));
    chk("R6 rst_kind high", rst_kind, 1);
    wr(1'b1, 16'hA500);
    rd(1'b1, v); chk("R8 flags cleared", v, 8'h00);

    // R1 reload mid-period restarts the prescaler
    wr(1'b0, 16'h5A00);
    wr(1'b1, 16'hA5C3);
    repeat (5) @(negedge clk);
    wr(1'b0, 16'h5AFF);
    wait_out(1'b0, n); chk("R1 full period after reload", n, period(3, 8'hFF));
    wr(1'b1, 16'hA500);

    // R7 interval mode
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA580);
    wait_out(1'b1, n); chk("R7 irq timing", n, period(0, 8'hFF));
    repeat (20) @(negedge clk);
    chk("R7 irq level held", irq, 1); chk("R7 no rst_req", rst_req, 0);
    rd(1'b1, v); chk("R7 iv flag", v, 8'h88);
    wr(1'b1, 16'hA588);
    chk("R8 write1 keeps irq", irq, 1);
    wr(1'b1, 16'hA580);
    chk("R8 irq cleared", irq, 0);
    wr(1'b1, 16'hA500);

    // R5 enable hold and resume
    wr(1'b0, 16'h5A10);
    wr(1'b1, 16'hA580);
    repeat (20) @(negedge clk);
    wr(1'b1, 16'hA500);
    rd(1'b0, v1);
    chk("R5 advanced while on", (v1 > 8'h10) ? 1 : 0, 1);
    repeat (50) @(negedge clk);
    rd(1'b0, v2); chk("R5 held while off", v2, v1);
    wr(1'b1, 16'hA580);
    repeat (20) @(negedge clk);
    wr(1'b1, 16'hA500);
    rd(1'b0, v2);
    chk("R5 resumed from held value", ((v2 > v1) && (v2 - v1 <= 8'd14)) ? 1 : 0, 1);

    // R4 random periods
    for (int i = 0; i < 4; i++) begin
      int code, start;
      code  = int'($urandom % 4);
      start = 240 + int'($urandom % 16);
      wr(1'b0, {8'h5A, 8'(start)});
      wr(1'b1, {8'hA5, 8'hC0 | 8'(code)});
      wait_out(1'b0, n); chk("R4 random period", n, period(code, start));
      wr(1'b1, 16'hA500);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule